// File: doc/BRIEF.md
# Lattice Percolation Monte Carlo Estimator

The block estimates how likely a square grid of randomly switched sites is to conduct from its top row to its bottom row. On each trial it fills every site in turn, turning a site on when a pseudo-random byte falls below a programmed site probability. It then floods the grid from the top row, stepping until no further site is reached, and records a success when the flood touches the bottom row.

A run starts with a one-cycle `start` pulse. It repeats trials until the programmed trial count is reached, then raises `done` and holds the trial and success counts. The ratio of the two counts is the estimated global connection probability. Two comparisons against programmed count thresholds tell whether the result can be read as a firm logic one or a firm logic zero. A force input turns every site on, so the flood path can be checked without randomness.

Top module: `perc_mc_est`

## Requirements
- R1: During reset and after it, `busy`, `done`, `one_pass` and `zero_pass` are 0 and both counters read 0 until a run starts.
- R2: The random source is a 16-bit right-shifting Galois LFSR. When bit 0 of the state is 1, the next state is (state >> 1) XOR 16'hB400; otherwise it is state >> 1. A run loads `seed`, with a zero seed replaced by 16'hACE1. The state carries on across the trials of one run.
- R3: Sites are filled one per cycle in row-major order (index row*SIDE+col, row 0 on top). Each site is ON when the low 8 bits of the current LFSR state, read as unsigned, are strictly less than `p1`. The LFSR then steps once.
- R4: With `force_on` high at start, every site is ON on every trial.
- R5: A trial succeeds when a chain of ON sites joined by orthogonal neighbours links row 0 to row SIDE-1. Each success adds 1 to `succ_cnt`, and every trial adds 1 to `trial_cnt`.
- R6: After the edge that samples `start`, a trial with no ON site in the top row takes SIDE*SIDE+1 cycles. A trial with all sites ON takes SIDE*SIDE+SIDE+1 cycles. `done` rises at the edge that ends the last trial.
- R7: A `trials` value of 0 raises `done` one cycle after start, with both counts 0.
- R8: Once `done` is high, both counts hold until the next `start`. A `start` pulse while `busy` is high has no effect.
- R9: `one_pass` is high exactly when `done` is high and `succ_cnt` >= `one_thr`. `zero_pass` is high exactly when `done` is high and `succ_cnt` <= `zero_thr`.
- R10: A `p1` of 0 yields zero successes, and forced sites yield a success on every trial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle run request |
| p1 | input | 8 | Site ON probability as a fraction of 256 |
| seed | input | 16 | LFSR seed (0 replaced by a constant) |
| trials | input | 16 | Number of trials in the run |
| force_on | input | 1 | Force every site ON |
| one_thr | input | 16 | Success count at or above which the result reads as one |
| zero_thr | input | 16 | Success count at or below which the result reads as zero |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, counts valid |
| succ_cnt | output | 16 | Trials with a top-to-bottom path |
| trial_cnt | output | 16 | Trials completed |
| one_pass | output | 1 | One-margin met |
| zero_pass | output | 1 | Zero-margin met |

## Verification
Trial latency is known exactly for two cases. With `p1` at 0, the flood settles on its first step, so `done` must appear T*(SIDE*SIDE+1) edges after the start edge. With forced sites, the flood needs one step per row plus one, so a trial takes SIDE*SIDE+SIDE+1 cycles. The bench counts falling edges from the start edge and samples `done` one cycle before the due edge and on it. For random fills, the bench replays the LFSR and a breadth-first flood of its own and compares the final counts once `done` is seen. Margin flags and held counts are sampled on falling edges after `done`.

// File: rtl/perc_pkg.sv
// Shared types for the percolation estimator.
// Assumes nothing beyond a standard package scope.
package perc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_FLOOD = 2'd2,
        ST_DONE  = 2'd3
    } perc_state_t;

    localparam logic [15:0] ZERO_SEED_SUB = 16'hACE1;
endpackage

// File: rtl/perc_lfsr.sv
// Galois LFSR, shifting right, used as the per-site random source.
// Assumes the seed given at load is nonzero; a zero seed is swapped for ALT_SEED.
module perc_lfsr #(
    parameter int          W        = 16,
    parameter logic [W-1:0] TAPS     = 16'hB400,
    parameter logic [W-1:0] ALT_SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] nxt;

    // Next state: shift right and apply the feedback mask when bit 0 leaves as 1.
    always_comb begin
        nxt = (state >> 1) ^ (state[0] ? TAPS : '0);
    end

    // State register: reset to ALT_SEED, load on start, step on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ALT_SEED;
        else if (load)
            state <= (seed == '0) ? ALT_SEED : seed;
        else if (step)
            state <= nxt;
    end
endmodule

// File: rtl/perc_flood.sv
// Flood engine: grows the set of sites reachable from the top row, one
// orthogonal step per advance, and flags when the set stops growing.
// Assumes sites are stable while advance is high.
module perc_flood #(
    parameter int SIDE = 6,
    localparam int NS  = SIDE * SIDE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    input  logic [NS-1:0] sites,
    output logic          settled,
    output logic          path
);
    logic [NS-1:0] reach;
    logic [NS-1:0] reach_nxt;

    // One flood step per site: ON and (top row or a reached neighbour or itself).
    for (genvar r = 0; r < SIDE; r++) begin : g_row
        for (genvar c = 0; c < SIDE; c++) begin : g_col
            localparam int K = r * SIDE + c;
            logic up_v, dn_v, lf_v, rt_v;
            if (r == 0) begin : g_top
                assign up_v = 1'b1;
            end else begin : g_mid_u
                assign up_v = reach[K-SIDE];
            end
            if (r == SIDE - 1) begin : g_bot
                assign dn_v = 1'b0;
            end else begin : g_mid_d
                assign dn_v = reach[K+SIDE];
            end
            if (c == 0) begin : g_lft
                assign lf_v = 1'b0;
            end else begin : g_mid_l
                assign lf_v = reach[K-1];
            end
            if (c == SIDE - 1) begin : g_rgt
                assign rt_v = 1'b0;
            end else begin : g_mid_r
                assign rt_v = reach[K+1];
            end
            assign reach_nxt[K] = sites[K] & (reach[K] | up_v | dn_v | lf_v | rt_v);
        end
    end

    assign settled = (reach_nxt == reach);
    assign path    = |reach_nxt[NS-1 -: SIDE];

    // Reach register: cleared before each trial, advanced during flooding.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            reach <= '0;
        else if (advance)
            reach <= reach_nxt;
    end
endmodule

// File: rtl/perc_mc_est.sv
// Monte Carlo percolation estimator: fills a SIDE x SIDE grid with random
// sites, floods it from the top, counts trials that reach the bottom.
// Assumes start is a pulse; start is ignored while a run is active.
module perc_mc_est
    import perc_pkg::*;
#(
    parameter int SIDE   = 6,
    parameter int CNT_W  = 16,
    parameter int PROB_W = 8,
    parameter int RND_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PROB_W-1:0] p1,
    input  logic [RND_W-1:0]  seed,
    input  logic [CNT_W-1:0]  trials,
    input  logic              force_on,
    input  logic [CNT_W-1:0]  one_thr,
    input  logic [CNT_W-1:0]  zero_thr,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  succ_cnt,
    output logic [CNT_W-1:0]  trial_cnt,
    output logic              one_pass,
    output logic              zero_pass
);
    localparam int NS    = SIDE * SIDE;
    localparam int IDX_W = (NS > 1) ? $clog2(NS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NS - 1);

    perc_state_t       st;
    logic [IDX_W-1:0]  idx;
    logic [NS-1:0]     sites;
    logic [CNT_W-1:0]  trials_q;
    logic [PROB_W-1:0] p1_q;
    logic              force_q;
    logic [RND_W-1:0]  rnd;
    logic              site_on;
    logic              settled;
    logic              path;
    logic              launch;
    logic              filling;
    logic              flooding;

    assign launch   = start && (st == ST_IDLE || st == ST_DONE);
    assign filling  = (st == ST_FILL);
    assign flooding = (st == ST_FLOOD);
    assign site_on  = force_q || (rnd[PROB_W-1:0] < p1_q);

    perc_lfsr #(
        .W(RND_W), .TAPS(RND_W'(16'hB400)), .ALT_SEED(RND_W'(ZERO_SEED_SUB))
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(launch), .seed(seed),
        .step(filling), .state(rnd)
    );

    perc_flood #(.SIDE(SIDE)) u_flood (
        .clk(clk), .rst_n(rst_n),
        .clear(filling && idx == LAST_IDX),
        .advance(flooding), .sites(sites),
        .settled(settled), .path(path)
    );

    // Run control: start, fill sites, flood, count, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            idx       <= '0;
            sites     <= '0;
            trials_q  <= '0;
            p1_q      <= '0;
            force_q   <= 1'b0;
            succ_cnt  <= '0;
            trial_cnt <= '0;
        end else if (launch) begin
            trials_q  <= trials;
            p1_q      <= p1;
            force_q   <= force_on;
            succ_cnt  <= '0;
            trial_cnt <= '0;
            idx       <= '0;
            st        <= (trials == '0) ? ST_DONE : ST_FILL;
        end else if (filling) begin
            sites[idx] <= site_on;
            if (idx == LAST_IDX) begin
                idx <= '0;
                st  <= ST_FLOOD;
            end else begin
                idx <= idx + 1'b1;
            end
        end else if (flooding && settled) begin
            succ_cnt  <= succ_cnt + CNT_W'(path);
            trial_cnt <= trial_cnt + 1'b1;
            st        <= (trial_cnt + 1'b1 == trials_q) ? ST_DONE : ST_FILL;
        end
    end

    // Status and margin flags, valid only once the run is done.
    always_comb begin
        busy      = filling || flooding;
        done      = (st == ST_DONE);
        one_pass  = done && (succ_cnt >= one_thr);
        zero_pass = done && (succ_cnt <= zero_thr);
    end
endmodule

// File: rtl/perc_mc_est_chk.sv
// Property checker for perc_mc_est, attached by bind.
// Assumes the port names of the top module.
module perc_mc_est_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] succ_cnt,
    input logic [CNT_W-1:0] trial_cnt,
    input logic             one_pass,
    input logic             zero_pass
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) !rst_n |=> !busy && !done && succ_cnt == '0 && trial_cnt == '0); // R1
    AST_SUCC_NOT_ABOVE_TRIALS: assert property (@(posedge clk) disable iff (!rst_n) succ_cnt <= trial_cnt); // R5
    AST_TRIAL_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (trial_cnt == $past(trial_cnt)) || (trial_cnt == $past(trial_cnt) + 1'b1)); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done && $stable(succ_cnt) && $stable(trial_cnt)); // R8
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done)); // R8
    AST_MARGIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !done |-> !one_pass && !zero_pass); // R9
endmodule

bind perc_mc_est perc_mc_est_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .succ_cnt(succ_cnt), .trial_cnt(trial_cnt),
    .one_pass(one_pass), .zero_pass(zero_pass)
);

// File: tb/sim_perc_mc_est.sv
// Directed bench for perc_mc_est with a software LFSR and flood model.
module sim_perc_mc_est;
    localparam int SIDE = 6;
    localparam int NS   = SIDE * SIDE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  p1 = '0;
    logic [15:0] seed = '0;
    logic [15:0] trials = '0;
    logic        force_on = 1'b0;
    logic [15:0] one_thr = '0;
    logic [15:0] zero_thr = '0;
    logic        busy, done, one_pass, zero_pass;
    logic [15:0] succ_cnt, trial_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    perc_mc_est #(.SIDE(SIDE)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .p1(p1), .seed(seed),
        .trials(trials), .force_on(force_on), .one_thr(one_thr),
        .zero_thr(zero_thr), .busy(busy), .done(done), .succ_cnt(succ_cnt),
        .trial_cnt(trial_cnt), .one_pass(one_pass), .zero_pass(zero_pass)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_step(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    // Reference: replay R2/R3 sampling and a breadth-first flood per R5.
    function automatic int model_succ(input logic [15:0] sd, input logic [7:0] pr, input bit frc, input int nt);
        logic [15:0] s;
        int succ;
        bit on[NS];
        bit rch[NS];
        s = (sd == 16'h0) ? 16'hACE1 : sd;
        succ = 0;
        for (int t = 0; t < nt; t++) begin
            for (int k = 0; k < NS; k++) begin
                on[k] = frc || (s[7:0] < pr);
                s = lfsr_step(s);
                rch[k] = 1'b0;
            end
            for (int c = 0; c < SIDE; c++) rch[c] = on[c];
            for (int it = 0; it < NS; it++) begin
                for (int k = 0; k < NS; k++) begin
                    if (on[k] && !rch[k]) begin
                        if ((k >= SIDE && rch[k-SIDE]) || (k < NS-SIDE && rch[k+SIDE]) ||
                            (k % SIDE != 0 && rch[k-1]) || (k % SIDE != SIDE-1 && rch[k+1]))
                            rch[k] = 1'b1;
                    end
                end
            end
            for (int c = 0; c < SIDE; c++) begin
                if (rch[NS-SIDE+c]) begin
                    succ++;
                    break;
                end
            end
        end
        return succ;
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 50000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic t_reset();
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "succ_cnt", succ_cnt, 0);
        check("R1", "trial_cnt", trial_cnt, 0);
        check("R1", "one/zero pass", {one_pass, zero_pass}, 0);
    endtask

    // p1 of 0: exact latency, no successes, margin flags.
    task automatic t_p1_zero();
        int per = NS + 1;
        p1 = 8'd0; force_on = 0; seed = 16'h1234; trials = 16'd20;
        one_thr = 16'd1; zero_thr = 16'd0;
        pulse_start();
        check("R9", "one_pass while busy", one_pass, 0);
        repeat (20 * per - 1) @(negedge clk);
        check("R6", "done one cycle early (p1=0)", done, 0);
        @(negedge clk);
        check("R6", "done on time (p1=0)", done, 1);
        check("R10", "succ_cnt with p1=0", succ_cnt, 0);
        check("R5", "trial_cnt p1=0", trial_cnt, 20);
        check("R9", "one_pass p1=0", one_pass, 0);
        check("R9", "zero_pass p1=0", zero_pass, 1);
    endtask

    // Forced sites: exact latency, every trial succeeds.
    task automatic t_force();
        int per = NS + SIDE + 1;
        force_on = 1; p1 = 8'd0; trials = 16'd10;
        one_thr = 16'd10; zero_thr = 16'd9;
        pulse_start();
        repeat (10 * per - 1) @(negedge clk);
        check("R6", "done one cycle early (forced)", done, 0);
        @(negedge clk);
        check("R6", "done on time (forced)", done, 1);
        check("R4", "succ_cnt forced", succ_cnt, 10);
        check("R10", "all forced trials succeed", succ_cnt, trial_cnt);
        check("R9", "one_pass at threshold", one_pass, 1);
        check("R9", "zero_pass above threshold", zero_pass, 0);
        repeat (30) @(negedge clk);
        check("R8", "succ_cnt held", succ_cnt, 10);
        check("R8", "done held", done, 1);
        force_on = 0;
    endtask

    task automatic t_random(input logic [15:0] sd, input logic [7:0] pr, input int nt, input string req);
        int exp_s;
        exp_s = model_succ(sd, pr, 1'b0, nt);
        p1 = pr; seed = sd; trials = 16'(nt); force_on = 0;
        one_thr = 16'(exp_s); zero_thr = 16'(exp_s);
        pulse_start();
        wait_done();
        check(req, "done after random run", done, 1);
        check(req, "succ_cnt random", succ_cnt, exp_s);
        check("R5", "trial_cnt random", trial_cnt, nt);
        check("R9", "both margins at equal thresholds", {one_pass, zero_pass}, 2'b11);
    endtask

    task automatic t_zero_trials();
        trials = 16'd0; p1 = 8'd255;
        pulse_start();
        check("R7", "done one cycle after start", done, 1);
        check("R7", "succ_cnt zero trials", succ_cnt, 0);
        check("R7", "trial_cnt zero trials", trial_cnt, 0);
    endtask

    task automatic t_start_while_busy();
        p1 = 8'd0; trials = 16'd5; seed = 16'h0042;
        pulse_start();
        repeat (10) @(negedge clk);
        trials = 16'd100;
        pulse_start();
        repeat (5 * (NS + 1) - 13) @(negedge clk);
        check("R8", "done not yet", done, 0);
        @(negedge clk);
        check("R8", "restart while busy ignored (done time)", done, 1);
        check("R8", "restart while busy ignored (trials)", trial_cnt, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_p1_zero();
        t_force();
        t_random(16'h1234, 8'd128, 200, "R3");
        t_random(16'h0000, 8'd160, 100, "R2");
        t_random(16'hBEEF, 8'd255, 50, "R3");
        t_random(16'h0001, 8'd100, 80, "R5");
        t_zero_trials();
        t_start_while_busy();
        finished = 1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule